// File: doc/BRIEF.md
# Serial ADC Result Output Port

This block is the digital output side of a 12-bit sampling converter that talks to a host over three wires: an active-low chip select, a serial clock and a single data-out line. The link is half duplex and carries data in one direction only. When the host pulls chip select low, the block waits through a short sample window counted in clock cycles. At the end of that window it captures the parallel result from the conversion core. It then drives one low null bit, followed by the result shifted most significant bit first.

Once the least significant bit has gone out, the block can optionally send the word a second time in reverse order. This second pass shares the B0 bit with the first, so it begins at B1 and ends at B11. After that the line holds low for as long as the clock keeps running. A mode input, captured with the result, turns the reversed pass off, so that zeros follow straight after B0.

Whenever chip select is high, the output is released to high impedance. This is modelled as an output-enable pin plus a data pin that reads low while the enable is low. Raising chip select ends or aborts the frame at once and returns the block to its idle state.

Top module: `adc_sout`

## Requirements
- R1: While cs_ni is high, dout_oe_o and dout_o are both low. Raising cs_ni clears dout_oe_o immediately, without waiting for a clock edge.
- R2: After cs_ni falls, the first two rising clock edges form the sample window, and dout_oe_o stays low through them. result_i and repeat_en_i are captured on the second rising edge.
- R3: On the falling edge that follows the sample window, dout_oe_o goes high and dout_o carries a null bit of value 0.
- R4: On the next 12 falling edges, dout_o carries the captured word from bit 11 down to bit 0, one bit per edge.
- R5: With the captured repeat_en_i equal to 1, the next 11 falling edges after bit 0 carry bits 1, 2 and so on up to 11. Bit 0 is not sent a second time.
- R6: After the last data bit, every further falling edge with cs_ni low drives dout_o to 0, for as long as the clock runs.
- R7: With the captured repeat_en_i equal to 0, dout_o is 0 on every falling edge after bit 0.
- R8: Changes on result_i or repeat_en_i after the capture edge have no effect on the rest of the frame.
- R9: A frame aborted by raising cs_ni part way through leaves no trace. The next frame starts with a fresh two-cycle sample window and sends its own word.
- R10: While rst_ni is low, dout_oe_o and dout_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock from the host |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select; a falling edge starts a frame |
| repeat_en_i | input | 1 | 1 selects the reversed second pass after B0 |
| result_i | input | 12 | Parallel conversion result from the core |
| dout_o | output | 1 | Serial data, changed on falling clock edges |
| dout_oe_o | output | 1 | High while the data line is driven; low means high impedance |

## Verification
The hardest conditions to reach are a chip-select abort at an arbitrary bit position, followed at once by a clean new frame, and the zero tail that only appears more than 25 edges into a frame. The stimulus uses seeded random frame lengths of up to 36 edges, with random words, modes and abort points. It adds directed frames that run past the reversed pass and one frame that changes result_i and repeat_en_i right after the capture edge. Every bit is compared against a bench model of the expected frame, indexed by the number of falling edges since chip select fell.

// File: rtl/adc_sout_pkg.sv
`timescale 1ns/1ps
package adc_sout_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_MSB  = 2'd1,
    SRC_LSB  = 2'd2
  } bit_src_e;
endpackage

// File: rtl/adc_sout_sampler.sv
`timescale 1ns/1ps
module adc_sout_sampler #(
  parameter int RES_W      = 12,
  parameter int SAMPLE_CYC = 2
) (
  input  logic             clk_i,
  input  logic             frame_rst_ni,
  input  logic [RES_W-1:0] result_i,
  input  logic             repeat_en_i,
  output logic             done_o,
  output logic [RES_W-1:0] word_o,
  output logic             rep_o
);
  localparam int CNT_W = $clog2(SAMPLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge frame_rst_ni) begin
    if (!frame_rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
      word_o <= '0;
      rep_o  <= 1'b0;
    end else if (!done_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        done_o <= 1'b1;
        word_o <= result_i;
        rep_o  <= repeat_en_i;
      end
    end
  end
endmodule

// File: rtl/adc_sout_seq.sv
`timescale 1ns/1ps
module adc_sout_seq #(
  parameter int RES_W = 12,
  localparam int SLOT_MAX = 2 * RES_W,
  localparam int SLOT_W   = $clog2(SLOT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              frame_rst_ni,
  input  logic              done_i,
  output logic              oe_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOT_MAX);

  // slot 0 = null, 1..RES_W = MSB pass, then LSB pass, LAST = zero tail
  always_ff @(negedge clk_i or negedge frame_rst_ni) begin
    if (!frame_rst_ni) begin
      oe_o   <= 1'b0;
      slot_o <= '0;
    end else if (!oe_o) begin
      if (done_i) oe_o <= 1'b1;
    end else if (slot_o != LAST) begin
      slot_o <= slot_o + 1'b1;
    end
  end
endmodule

// File: rtl/adc_sout_mux.sv
`timescale 1ns/1ps
module adc_sout_mux
  import adc_sout_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int SLOT_W = $clog2(2 * RES_W + 1),
  localparam int IDX_W  = $clog2(RES_W)
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [RES_W-1:0]  word_i,
  input  logic              rep_i,
  input  logic              oe_i,
  output logic              dout_o
);
  localparam logic [SLOT_W-1:0] RES_S = SLOT_W'(RES_W);
  localparam logic [SLOT_W-1:0] END_S = SLOT_W'(2 * RES_W);

  bit_src_e        src;
  logic [IDX_W-1:0] idx;

  always_comb begin
    src = SRC_ZERO;
    idx = '0;
    if (oe_i && slot_i != '0) begin
      if (slot_i <= RES_S) begin
        src = SRC_MSB;
        idx = IDX_W'(RES_S - slot_i);
      end else if (rep_i && slot_i < END_S) begin
        src = SRC_LSB;
        idx = IDX_W'(slot_i - RES_S);
      end
    end
  end

  assign dout_o = (src == SRC_ZERO) ? 1'b0 : word_i[idx];
endmodule

// File: rtl/adc_sout.sv
`timescale 1ns/1ps
module adc_sout #(
  parameter int RES_W      = 12,
  parameter int SAMPLE_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             repeat_en_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             dout_oe_o
);
  localparam int SLOT_W = $clog2(2 * RES_W + 1);

  logic              frame_rst_n;
  logic              sample_done;
  logic [RES_W-1:0]  word_q;
  logic              rep_q;
  logic [SLOT_W-1:0] slot;

  // chip select high acts as an asynchronous frame clear
  assign frame_rst_n = rst_ni & ~cs_ni;

  adc_sout_sampler #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) u_sampler (
    .clk_i        (clk_i),
    .frame_rst_ni (frame_rst_n),
    .result_i     (result_i),
    .repeat_en_i  (repeat_en_i),
    .done_o       (sample_done),
    .word_o       (word_q),
    .rep_o        (rep_q)
  );

  adc_sout_seq #(.RES_W(RES_W)) u_seq (
    .clk_i        (clk_i),
    .frame_rst_ni (frame_rst_n),
    .done_i       (sample_done),
    .oe_o         (dout_oe_o),
    .slot_o       (slot)
  );

  adc_sout_mux #(.RES_W(RES_W)) u_mux (
    .slot_i (slot),
    .word_i (word_q),
    .rep_i  (rep_q),
    .oe_i   (dout_oe_o),
    .dout_o (dout_o)
  );
endmodule

// File: rtl/adc_sout_chk.sv
`timescale 1ns/1ps
module adc_sout_chk #(
  parameter int RES_W = 12,
  localparam int SLOT_W = $clog2(2 * RES_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              dout_o,
  input logic              dout_oe_o,
  input logic              sample_done,
  input logic [RES_W-1:0]  word_q,
  input logic              rep_q,
  input logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(2 * RES_W);
  localparam logic [SLOT_W-1:0] RES_S = SLOT_W'(RES_W);

  assert_hiz_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!dout_oe_o && !dout_o));

  assert_quiet_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    !sample_done |-> !dout_oe_o);

  assert_null_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (dout_oe_o && slot == '0) |-> !dout_o);

  assert_slot_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (dout_oe_o && $past(dout_oe_o) && $past(slot) != LAST) |-> (slot == SLOT_W'($past(slot) + 1'b1)));

  assert_tail_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (slot == LAST) |-> !dout_o);

  assert_norep_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (!rep_q && slot > RES_S) |-> !dout_o);

  assert_word_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (sample_done && $past(sample_done)) |-> ($stable(word_q) && $stable(rep_q)));
endmodule

bind adc_sout adc_sout_chk #(.RES_W(RES_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .dout_o      (dout_o),
  .dout_oe_o   (dout_oe_o),
  .sample_done (sample_done),
  .word_q      (word_q),
  .rep_q       (rep_q),
  .slot        (slot)
);

// File: tb/adc_sout_test.sv
`timescale 1ns/1ps
module adc_sout_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rep_en = 1'b0;
  logic [11:0] res = '0;
  logic        dout, oe;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit prev_abort = 0;

  always #2 clk = ~clk;

  adc_sout uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .repeat_en_i(rep_en),
    .result_i(res), .dout_o(dout), .dout_oe_o(oe)
  );

  function automatic logic exp_bit(logic [11:0] w, logic r, int s);
    if (s <= 0) return 1'b0;
    if (s <= 12) return w[12-s];
    if (r && s < 24) return w[s-12];
    return 1'b0;
  endfunction

  function automatic string tag_of(logic r, int s);
    if (s < 0) return "R2";
    if (s == 0) return "R3";
    if (s <= 12) return "R4";
    if (s < 24) return r ? "R5" : "R7";
    return "R6";
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // called just after a falling edge; runs len falling edges then raises cs
  task automatic run_frame(logic [11:0] w, logic r, int len, bit disturb, bit abort);
    res = w; rep_en = r; cs_n = 1'b0;
    for (int n = 1; n <= len; n++) begin
      int s;
      string t;
      @(negedge clk); #1;
      s = n - 2;
      t = disturb && n > 2 ? "R8" : (prev_abort ? "R9" : tag_of(r, s));
      chk(t, oe, n >= 2);
      chk(t, dout, exp_bit(w, r, s));
      if (disturb && n == 2) begin res = ~w; rep_en = ~r; end
    end
    cs_n = 1'b1; #1;
    chk(abort ? "R9" : "R1", oe, 1'b0);
    chk("R1", dout, 1'b0);
    repeat (2) @(negedge clk);
    #1;
    chk("R1", oe, 1'b0);
    prev_abort = abort;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed1285);
    #1;
    chk("R10", oe, 1'b0);
    chk("R10", dout, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", oe, 1'b0);
    // directed corners
    run_frame(12'hA5C, 1'b1, 40, 0, 0);
    run_frame(12'h801, 1'b0, 30, 0, 0);
    run_frame(12'hFFF, 1'b1, 34, 0, 0);
    run_frame(12'hFFF, 1'b0, 20, 0, 0);
    run_frame(12'h3C7, 1'b1, 6, 0, 1);
    run_frame(12'h555, 1'b1, 30, 0, 0);
    run_frame(12'h1B4, 1'b0, 1, 0, 1);
    run_frame(12'h9E1, 1'b0, 28, 0, 0);
    run_frame(12'h6D3, 1'b1, 32, 1, 0);
    // seeded random frames
    for (int i = 0; i < 30; i++) begin
      logic [11:0] w;
      logic r;
      int len;
      w = 12'($urandom);
      r = 1'($urandom);
      len = 1 + int'($urandom_range(35));
      run_frame(w, r, len, 0, len < 26);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule